// File: doc/BRIEF.md
# Probabilistic One-Hot Response Selector

This block turns a 2-bit stimulus into one of four one-hot response lines. The choice is pseudo-random, and each stimulus has its own fixed probabilities, counted in eighths. A single token circulates around an 8-stage ring that starts itself after reset. For each stimulus value, a parameter table assigns every ring position to exactly one response. The current stimulus selects which table drives the candidate response, so the token's position at a given moment decides the outcome.

The registered response changes only on the clock edge that captures a new stimulus value, and holds between changes. A second output gives the held response as a 2-bit binary index. A stimulus that is held constant therefore keeps its response. Which response appears after a change depends on where the token was at that edge, so a response that owns k table positions appears with probability k/8.

Top module: `resp_select`

## Requirements
- R1: The ring never holds more than one high bit, and the response output never has more than one line high.
- R2: A synchronous active-low reset clears the ring, the sampled stimulus and the response to zero, so the code reads 00. On the first clock after reset is released, the token appears at ring position 0.
- R3: When the ring is empty, position 0 loads a 1. Otherwise the token moves one position toward higher index on every clock, and position 7 wraps to position 0.
- R4: MAP bits [(s*8+p)*2 +: 2] hold the response index for stimulus s when the token is at position p. Every position maps to exactly one response.
- R5: The candidate response is the one-hot line named by the MAP entry for the stimulus on the input and the token position before the edge. Exactly one candidate line is high while the ring holds the token.
- R6: On a clock edge where the stimulus input differs from the value sampled on the previous edge, the response register loads the candidate.
- R7: On a clock edge where the stimulus equals the previously sampled value, the response keeps its value.
- R8: resp_code equals n when response line n (index 0 to 3) is high, and 00 when no line is high.
- R9: If a stimulus s is captured once at each of the 8 ring positions, each response appears exactly as many times as the MAP entries of s name it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stim | input | 2 | Stimulus value |
| resp | output | 4 | Held one-hot response |
| resp_code | output | 2 | Binary index of the held response |

## Verification
A stimulus change is set up before a rising edge, and the response and its code are due right after that same edge, one register stage later. A stimulus that is held must leave both outputs unchanged on every later edge. The bench drives stimulus on the falling edge and compares at the next falling edge. Its expected values come from its own count of token position since reset: the token is at position 0 before the second edge after release and moves one step per clock. The distribution test repeats a three-cycle pattern. Because 3 and 8 share no factor, the stimulus under test is captured at all eight ring positions.

// File: rtl/rsel_pkg.sv
// Shared sizes and the default position-to-response table.
// Assumes: each 2-bit table entry names a response index 0..3.
package rsel_pkg;
    localparam int STIM_W   = 2;
    localparam int RING_LEN = 8;
    localparam int N_RESP   = 4;
    // Entry for stimulus s, position p sits at [(s*RING_LEN+p)*2 +: 2].
    // s0: 4/8 r0, 2/8 r1, 1/8 r2, 1/8 r3; s1: 3/8 r1, 3/8 r2, 2/8 r3;
    // s2: always r2; s3: 2/8 each.
    localparam logic [63:0] DEF_MAP = 64'hE4E4_AAAA_E667_E500;
endpackage

// File: rtl/rsel_token_ring.sv
// Circulating single-token ring that starts itself.
// Assumes: reset leaves the ring empty; an empty ring injects at position 0.
module rsel_token_ring #(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [LEN-1:0] ring
);
    // Inject a token when empty, else rotate toward higher index.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ring <= '0;
        else if (ring == '0)
            ring <= LEN'(1);
        else
            ring <= {ring[LEN-2:0], ring[LEN-1]};
    end

    a_r1_single_token: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ring));
    a_r3_inject: assert property (@(posedge clk) disable iff (!rst_n)
        (ring == '0) |=> (ring == LEN'(1)));
    a_r3_rotate: assert property (@(posedge clk) disable iff (!rst_n)
        (ring != '0) |=> (ring == {$past(ring[LEN-2:0]), $past(ring[LEN-1])}));
endmodule

// File: rtl/rsel_map_select.sv
// Position-to-response OR network per stimulus plus the stimulus selector.
// Assumes: ring carries at most one high bit, so at most one line is high.
module rsel_map_select #(
    parameter int STIM_W = 2,
    parameter int LEN    = 8,
    parameter int N_RESP = 4,
    parameter int IDX_W  = 2,
    parameter logic [(2**STIM_W)*LEN*IDX_W-1:0] MAP = '0
) (
    input  logic [LEN-1:0]    ring,
    input  logic [STIM_W-1:0] stim,
    output logic [N_RESP-1:0] cand
);
    localparam int N_STIM = 2 ** STIM_W;

    // Ring positions that a given stimulus routes to a given response.
    function automatic logic [LEN-1:0] pos_mask(input int s, input int r);
        logic [LEN-1:0] m;
        m = '0;
        for (int p = 0; p < LEN; p++)
            m[p] = (int'(MAP[(s*LEN+p)*IDX_W +: IDX_W]) == r);
        return m;
    endfunction

    logic [N_STIM-1:0][N_RESP-1:0] lines;

    for (genvar s = 0; s < N_STIM; s++) begin : g_stim
        for (genvar r = 0; r < N_RESP; r++) begin : g_resp
            localparam logic [LEN-1:0] MASK = pos_mask(s, r);
            // One response line: OR of the ring positions assigned to it.
            assign lines[s][r] = |(ring & MASK);
        end
    end

    // The stimulus picks its own mapping.
    assign cand = lines[stim];
endmodule

// File: rtl/rsel_hold_out.sv
// Stimulus sampler and held response register with a change-only enable.
// Assumes: cand is computed from the live stimulus input.
module rsel_hold_out #(
    parameter int STIM_W = 2,
    parameter int N_RESP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STIM_W-1:0] stim,
    input  logic [N_RESP-1:0] cand,
    output logic [N_RESP-1:0] resp
);
    logic [STIM_W-1:0] stim_q;
    logic              chg;

    // Stimulus differs from the value captured on the last edge.
    assign chg = |(stim ^ stim_q);

    // Sample the stimulus each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) stim_q <= '0;
        else        stim_q <= stim;
    end

    // Load the candidate only on the edge that captures a change.
    always_ff @(posedge clk) begin
        if (!rst_n)   resp <= '0;
        else if (chg) resp <= cand;
    end

    a_r6_load: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (resp == $past(cand)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !chg |=> $stable(resp));
endmodule

// File: rtl/rsel_encode.sv
// One-hot to binary index encoder for the held response.
// Assumes: at most one input line is high; none high gives zero.
module rsel_encode #(
    parameter int N_RESP = 4,
    parameter int IDX_W  = 2
) (
    input  logic [N_RESP-1:0] onehot,
    output logic [IDX_W-1:0]  idx
);
    // OR together the indices of the high lines.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N_RESP; i++)
            if (onehot[i]) idx = idx | IDX_W'(i);
    end
endmodule

// File: rtl/resp_select.sv
// Probabilistic one-hot response selector: ring, mapping network,
// change-only hold register and binary encoder.
// Assumes: stim is synchronous to clk; MAP holds 2**STIM_W tables.
module resp_select #(
    parameter int STIM_W   = rsel_pkg::STIM_W,
    parameter int RING_LEN = rsel_pkg::RING_LEN,
    parameter int N_RESP   = rsel_pkg::N_RESP,
    parameter logic [(2**STIM_W)*RING_LEN*$clog2(N_RESP)-1:0] MAP = rsel_pkg::DEF_MAP
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [STIM_W-1:0]          stim,
    output logic [N_RESP-1:0]          resp,
    output logic [$clog2(N_RESP)-1:0]  resp_code
);
    localparam int IDX_W = $clog2(N_RESP);

    logic [RING_LEN-1:0] ring;
    logic [N_RESP-1:0]   cand;

    rsel_token_ring #(.LEN(RING_LEN)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .ring  (ring)
    );

    rsel_map_select #(
        .STIM_W (STIM_W),
        .LEN    (RING_LEN),
        .N_RESP (N_RESP),
        .IDX_W  (IDX_W),
        .MAP    (MAP)
    ) u_map (
        .ring (ring),
        .stim (stim),
        .cand (cand)
    );

    rsel_hold_out #(.STIM_W(STIM_W), .N_RESP(N_RESP)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .stim  (stim),
        .cand  (cand),
        .resp  (resp)
    );

    rsel_encode #(.N_RESP(N_RESP), .IDX_W(IDX_W)) u_enc (
        .onehot (resp),
        .idx    (resp_code)
    );

    a_r5_cand_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (ring != '0) |-> $onehot(cand));
    a_r1_resp_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(resp));
    a_r8_code_match: assert property (@(posedge clk) disable iff (!rst_n)
        (resp != '0) |-> resp[resp_code]);
endmodule

// File: tb/resp_select_tb.sv
`timescale 1ns/1ps
module resp_select_tb;
    localparam logic [63:0] MAP = 64'hE4E4_AAAA_E667_E500;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] stim = 2'd0;
    logic [3:0] resp;
    logic [1:0] resp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    resp_select #(.MAP(MAP)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .stim      (stim),
        .resp      (resp),
        .resp_code (resp_code)
    );

    function automatic logic [1:0] map_at(input logic [1:0] s, input logic [2:0] p);
        return MAP[(int'(s)*8 + int'(p))*2 +: 2];
    endfunction

    // Reference: token position counted since reset, stimulus history.
    logic       m_valid = 1'b0;
    logic [2:0] m_pos = 3'd0;
    logic [1:0] m_stim = 2'd0;
    logic [3:0] m_resp = 4'd0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0; m_pos <= 3'd0; m_stim <= 2'd0; m_resp <= 4'd0;
        end else begin
            if (stim != m_stim)
                m_resp <= m_valid ? (4'd1 << map_at(stim, m_pos)) : 4'd0;
            m_stim <= stim;
            if (!m_valid) begin m_valid <= 1'b1; m_pos <= 3'd0; end
            else m_pos <= m_pos + 3'd1;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [1:0] idx_of(input logic [3:0] oh);
        logic [1:0] r = 2'd0;
        for (int i = 0; i < 4; i++) if (oh[i]) r = 2'(i);
        return r;
    endfunction

    // Compare both outputs against the reference, including the encoding.
    task automatic check_outputs(input string tag);
        check({tag, " resp"}, 32'(resp), 32'(m_resp));
        check("R8 code", 32'(resp_code), 32'(idx_of(m_resp)));
        check("R1 onehot0", 32'($countones(resp) <= 1), 32'd1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; stim = 2'd0;
        repeat (3) step();
        check("R2 reset resp", 32'(resp), 32'd0);
        check("R2 reset code", 32'(resp_code), 32'd0);
        rst_n = 1'b1;
        step();
        check("R7 idle after reset", 32'(resp), 32'd0);
    endtask

    // The second edge after release sees the token at position 0.
    task automatic t_first_capture();
        stim = 2'd1;
        step();
        check("R2 token at pos0", 32'(resp), 32'(4'd1 << map_at(2'd1, 3'd0)));
        check_outputs("R6 first");
    endtask

    task automatic t_hold();
        logic [3:0] held;
        held = resp;
        for (int i = 0; i < 10; i++) begin
            step();
            check("R7 hold", 32'(resp), 32'(held));
        end
    endtask

    // Stimulus changes at varied spacing so captures land at many positions.
    task automatic t_walk();
        logic [1:0] seq [6] = '{2'd3, 2'd0, 2'd2, 2'd1, 2'd3, 2'd0};
        for (int k = 0; k < 6; k++) begin
            stim = seq[k];
            step();
            check_outputs("R5 R6 R3 capture");
            for (int w = 0; w < k; w++) begin
                step();
                check_outputs("R7 walk hold");
            end
        end
    endtask

    // Capture stimulus s at all eight ring positions (3-cycle period).
    task automatic t_distribution(input logic [1:0] s);
        int got [4];
        int exp [4];
        for (int r = 0; r < 4; r++) begin got[r] = 0; exp[r] = 0; end
        for (int p = 0; p < 8; p++) exp[map_at(s, 3'(p))]++;
        for (int t = 0; t < 8; t++) begin
            stim = s ^ 2'd1;
            step();
            step();
            stim = s;
            step();
            check_outputs("R9 R4 sample");
            got[idx_of(resp)]++;
        end
        for (int r = 0; r < 4; r++)
            check($sformatf("R9 count s%0d r%0d", s, r), 32'(got[r]), 32'(exp[r]));
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        step();
        check("R2 mid reset resp", 32'(resp), 32'd0);
        check("R2 mid reset code", 32'(resp_code), 32'd0);
        stim = 2'd0;
        rst_n = 1'b1;
        step();
        stim = 2'd3;
        step();
        check("R2 restart pos0", 32'(resp), 32'(4'd1 << map_at(2'd3, 3'd0)));
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_first_capture();
        t_hold();
        t_walk();
        for (int s = 0; s < 4; s++) t_distribution(2'(s));
        t_hold();
        t_reset_mid();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule